// File: doc/BRIEF.md
# External Bus Byte-Lane Strobe Generator

This block turns a transfer request (size code, the two low address bits, direction) into the active-low lane strobes of an external bus port. The port can be configured as 32 bits or 16 bits wide. Lanes are numbered big-endian: strobe 0 covers the most significant byte of the data bus. A single mode input selects how the strobes behave. In write-strobe mode they pulse only on writes. In lane-enable mode they pulse on reads and on writes, with the same timing in both cases.

A request is taken when `req_valid` is high while `req_ready` is high. Each external beat lasts one clock cycle, starting in the cycle after acceptance. A word request to a 16-bit port is run as two back-to-back 16-bit beats. Both beats use strobes 0 and 1 only, and `ext_addr_hw` tells the two halves apart. A misaligned request, or one with a reserved size code, produces a one-cycle error pulse and no strobes.

Top module: `lane_strobe_gen`

## Requirements
- R1: While reset is low, and in every idle cycle, `lane_en_n` is 4'b1111, `done` and `err` are 0 and `req_ready` is 1.
- R2: On a 32-bit port (`port_half`=0), a byte request (`req_size`=2'b01) at offset 0, 1, 2 or 3 pulls low only `lane_en_n[0]`, `[1]`, `[2]` or `[3]` respectively, for one cycle.
- R3: On a 32-bit port, a halfword (`req_size`=2'b10) at offset 0 pulls low lanes 0 and 1, and one at offset 2 pulls low lanes 2 and 3. A word or burst (`req_size`=2'b00) at offset 0 pulls low all four lanes for one cycle.
- R4: On a 16-bit port (`port_half`=1), a byte pulls low lane 0 when `req_addr[0]`=0 and lane 1 when it is 1. A halfword pulls low lanes 0 and 1. Lanes 2 and 3 never go low.
- R5: A word request on a 16-bit port runs two consecutive one-cycle beats, each pulling low only lanes 0 and 1. `ext_addr_hw` is 0 in the first beat and 1 in the second. `done` is high only in the second beat.
- R6: With `strobe_mode`=0, a read (`req_write`=0) pulls no lane low but still completes with `done`. With `strobe_mode`=1, a read pulls low the same lanes, in the same cycle, as a write would.
- R7: A halfword at an odd offset, a word at a nonzero offset, or size code 2'b11 raises `err` for exactly one cycle after acceptance. No lane goes low and `done` stays 0.
- R8: `req_ready` is low from the cycle after acceptance until the cycle after `done` or `err`. A request presented while busy is ignored. The block returns to idle in the cycle after `done`.
- R9: In a single-beat transfer, `ext_addr_hw` equals the accepted `req_addr[1]` during the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_size | input | 2 | 01 byte, 10 halfword, 00 word/burst, 11 reserved |
| req_addr | input | 2 | Low two address bits of the transfer |
| req_write | input | 1 | 1 write, 0 read |
| port_half | input | 1 | 1 selects a 16-bit external port, 0 a 32-bit port |
| strobe_mode | input | 1 | 0 write-only strobes, 1 read/write lane enables |
| lane_en_n | output | 4 | Active-low lane strobes, bit 0 is the most significant byte |
| ext_addr_hw | output | 1 | External halfword address bit for the current beat |
| done | output | 1 | Last beat of an accepted transfer |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The hardest situation to reach from the ports is a second request arriving while a split word transfer is still busy. The sequencer must not let that request disturb the second beat's lanes or its address bit. The stimulus therefore keeps `req_valid` high with a different byte request for one cycle after every acceptance. It then checks the following beats and the idle cycle that comes after them. This is done across the full sweep of size, offset, direction, port width and mode, so both split and single-beat transfers, and error responses, all meet the stray request.

// File: rtl/lane_strobe_pkg.sv
// Shared constants and types for the lane strobe generator.
// Assumes a four-lane external bus, of which a half-width port uses the
// two most significant lanes.
package lane_strobe_pkg;

    localparam int unsigned LANE_CNT      = 4;
    localparam int unsigned HALF_LANES    = LANE_CNT / 2;
    localparam int unsigned OFS_W         = $clog2(LANE_CNT);

    // Transfer size codes seen on req_size.
    localparam logic [1:0] SZ_WORD = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_HALF = 2'b10;
    localparam logic [1:0] SZ_RSVD = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT1 = 2'd1,
        ST_BEAT2 = 2'd2,
        ST_ERR   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/lane_mask_decode.sv
// Combinational lane selection: maps size, offset and port width onto the
// set of big-endian byte lanes a beat uses, and flags misaligned or
// reserved requests. Assumes lane 0 is the most significant byte.
module lane_mask_decode
    import lane_strobe_pkg::*;
(
    input  logic [1:0]          size,
    input  logic [OFS_W-1:0]    ofs,
    input  logic                half_port,
    output logic [LANE_CNT-1:0] mask,
    output logic                split,
    output logic                misaligned
);

    // Per-lane hit decode, one copy per lane.
    for (genvar k = 0; k < LANE_CNT; k++) begin : g_lane
        localparam int unsigned KI      = k;
        localparam logic        IN_HALF = (KI < HALF_LANES);
        localparam logic [OFS_W-1:0] KOFS = KI[OFS_W-1:0];
        logic byte_hit;
        logic half_hit;
        logic word_hit;

        assign byte_hit = half_port ? (IN_HALF && (ofs[0] == KOFS[0]))
                                    : (ofs == KOFS);
        assign half_hit = half_port ? IN_HALF
                                    : (ofs[OFS_W-1] == KOFS[OFS_W-1]);
        assign word_hit = half_port ? IN_HALF : 1'b1;

        assign mask[k] = ((size == SZ_BYTE) && byte_hit) ||
                         ((size == SZ_HALF) && half_hit) ||
                         ((size == SZ_WORD) && word_hit);
    end

    // Alignment and reserved-code check.
    always_comb begin
        misaligned = 1'b0;
        case (size)
            SZ_HALF: misaligned = ofs[0];
            SZ_WORD: misaligned = (ofs != '0);
            SZ_RSVD: misaligned = 1'b1;
            default: misaligned = 1'b0;
        endcase
    end

    // A word on a half-width port needs two beats.
    assign split = half_port && (size == SZ_WORD);

endmodule

// File: rtl/beat_sequencer.sv
// Request acceptance and beat sequencing. Captures an accepted request and
// steps IDLE -> BEAT1 [-> BEAT2] -> IDLE, or IDLE -> ERR -> IDLE for a
// rejected request. Assumes requests are only taken while idle.
module beat_sequencer
    import lane_strobe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_size,
    input  logic                req_write,
    input  logic                req_addr_hi,
    input  logic                port_half,
    input  logic                strobe_mode,
    input  logic [LANE_CNT-1:0] dec_mask,
    input  logic                dec_split,
    input  logic                dec_misaligned,
    output seq_state_t          state,
    output logic [LANE_CNT-1:0] mask_q,
    output logic [1:0]          size_q,
    output logic                split_q,
    output logic                write_q,
    output logic                mode_q,
    output logic                half_q,
    output logic                addr_hi_q
);

    logic accept;
    assign accept = req_valid && (state == ST_IDLE);

    // Next-state register for the beat sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (accept) state <= dec_misaligned ? ST_ERR : ST_BEAT1;
                ST_BEAT1: state <= split_q ? ST_BEAT2 : ST_IDLE;
                ST_BEAT2: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Capture of the accepted request's fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            size_q    <= SZ_BYTE;
            split_q   <= 1'b0;
            write_q   <= 1'b0;
            mode_q    <= 1'b0;
            half_q    <= 1'b0;
            addr_hi_q <= 1'b0;
        end else if (accept) begin
            mask_q    <= dec_misaligned ? '0 : dec_mask;
            size_q    <= req_size;
            split_q   <= dec_split && !dec_misaligned;
            write_q   <= req_write;
            mode_q    <= strobe_mode;
            half_q    <= port_half;
            addr_hi_q <= req_addr_hi;
        end
    end

    a_r5_second_beat_follows_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEAT2) |-> ($past(state) == ST_BEAT1));
    a_r7_err_lasts_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERR) |=> (state == ST_IDLE));
    a_r8_no_reaccept_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BEAT1) |=> (state != ST_BEAT1));

endmodule

// File: rtl/strobe_drive.sv
// Output stage: forms the active-low lane strobes, the halfword address bit,
// and the done/err pulses from the sequencer state. Assumes the captured
// mask is already limited to the lanes the port width allows.
module strobe_drive
    import lane_strobe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  seq_state_t          state,
    input  logic [LANE_CNT-1:0] mask_q,
    input  logic [1:0]          size_q,
    input  logic                split_q,
    input  logic                write_q,
    input  logic                mode_q,
    input  logic                half_q,
    input  logic                addr_hi_q,
    output logic [LANE_CNT-1:0] lane_en_n,
    output logic                ext_addr_hw,
    output logic                done,
    output logic                err
);

    logic in_beat;
    logic qualify;

    assign in_beat = (state == ST_BEAT1) || (state == ST_BEAT2);
    // Write strobes need a write; lane enables fire on either direction.
    assign qualify = write_q || mode_q;

    // Strobe and address formation for the current beat.
    always_comb begin
        lane_en_n   = '1;
        ext_addr_hw = 1'b0;
        if (in_beat) begin
            if (qualify) lane_en_n = ~mask_q;
            ext_addr_hw = split_q ? (state == ST_BEAT2) : addr_hi_q;
        end
    end

    // Completion and error pulses.
    assign done = (state == ST_BEAT2) || ((state == ST_BEAT1) && !split_q);
    assign err  = (state == ST_ERR);

    a_r4_half_port_upper_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
        half_q |-> (lane_en_n[LANE_CNT-1:HALF_LANES] == '1));
    a_r6_write_mode_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !write_q) |-> (&lane_en_n));
    a_r7_err_without_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ((&lane_en_n) && !done));
    a_r2_byte_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (size_q == SZ_BYTE) |-> ($countones(~lane_en_n) <= 1));
    a_r8_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

endmodule

// File: rtl/lane_strobe_gen.sv
// Top level of the lane strobe generator: decodes a request into byte lanes,
// sequences one or two external beats, and drives active-low strobes.
// Assumes a synchronous active-low reset and a single clock domain.
module lane_strobe_gen
    import lane_strobe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_size,
    input  logic [OFS_W-1:0]    req_addr,
    input  logic                req_write,
    input  logic                port_half,
    input  logic                strobe_mode,
    output logic [LANE_CNT-1:0] lane_en_n,
    output logic                ext_addr_hw,
    output logic                done,
    output logic                err
);

    logic [LANE_CNT-1:0] dec_mask;
    logic                dec_split;
    logic                dec_misaligned;
    seq_state_t          state;
    logic [LANE_CNT-1:0] mask_q;
    logic [1:0]          size_q;
    logic                split_q;
    logic                write_q;
    logic                mode_q;
    logic                half_q;
    logic                addr_hi_q;

    lane_mask_decode i_decode (
        .size       (req_size),
        .ofs        (req_addr),
        .half_port  (port_half),
        .mask       (dec_mask),
        .split      (dec_split),
        .misaligned (dec_misaligned)
    );

    beat_sequencer i_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_size       (req_size),
        .req_write      (req_write),
        .req_addr_hi    (req_addr[OFS_W-1]),
        .port_half      (port_half),
        .strobe_mode    (strobe_mode),
        .dec_mask       (dec_mask),
        .dec_split      (dec_split),
        .dec_misaligned (dec_misaligned),
        .state          (state),
        .mask_q         (mask_q),
        .size_q         (size_q),
        .split_q        (split_q),
        .write_q        (write_q),
        .mode_q         (mode_q),
        .half_q         (half_q),
        .addr_hi_q      (addr_hi_q)
    );

    strobe_drive i_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (state),
        .mask_q      (mask_q),
        .size_q      (size_q),
        .split_q     (split_q),
        .write_q     (write_q),
        .mode_q      (mode_q),
        .half_q      (half_q),
        .addr_hi_q   (addr_hi_q),
        .lane_en_n   (lane_en_n),
        .ext_addr_hw (ext_addr_hw),
        .done        (done),
        .err         (err)
    );

    assign req_ready = (state == ST_IDLE);

    a_r1_idle_strobes_off: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((&lane_en_n) && !done && !err));
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

endmodule

// File: tb/test_lane_strobe_gen.sv
`timescale 1ns/1ps
module test_lane_strobe_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_size = 2'b01;
    logic [1:0] req_addr = 2'b00;
    logic       req_write = 1'b0;
    logic       port_half = 1'b0;
    logic       strobe_mode = 1'b0;
    logic [3:0] lane_en_n;
    logic       ext_addr_hw;
    logic       done;
    logic       err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lane_strobe_gen i_lane_strobe_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_size(req_size), .req_addr(req_addr), .req_write(req_write),
        .port_half(port_half), .strobe_mode(strobe_mode), .lane_en_n(lane_en_n),
        .ext_addr_hw(ext_addr_hw), .done(done), .err(err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            finish_run();
        end
    end

    // Expected active lane set per R2, R3, R4 (bit k = lane k).
    function automatic logic [3:0] exp_mask(input logic [1:0] sz, input logic [1:0] a, input logic hp);
        case (sz)
            2'b01:   return hp ? (4'b0001 << a[0]) : (4'b0001 << a);
            2'b10:   return (hp || !a[1]) ? 4'b0011 : 4'b1100;
            2'b00:   return hp ? 4'b0011 : 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic bit exp_bad(input logic [1:0] sz, input logic [1:0] a);
        return (sz == 2'b11) || (sz == 2'b10 && a[0]) || (sz == 2'b00 && a != 2'b00);
    endfunction

    task automatic check_idle(input string tag);
        check(lane_en_n == 4'hF, {tag, " R1 lanes idle"}, lane_en_n, 4'hF);
        check(!done && !err, {tag, " R1 no done/err idle"}, {done, err}, 0);
        check(req_ready, {tag, " R8 ready in idle"}, req_ready, 1);
    endtask

    initial begin
        // Reset phase: outputs are inactive while reset is low (R1).
        repeat (3) @(negedge clk);
        check_idle("reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("after reset");

        for (int sz = 0; sz < 4; sz++)
        for (int ad = 0; ad < 4; ad++)
        for (int hp = 0; hp < 2; hp++)
        for (int wr = 0; wr < 2; wr++)
        for (int md = 0; md < 2; md++) begin
            logic [3:0] m;
            logic [3:0] lanes;
            bit         bad;
            bit         spl;
            m     = exp_mask(sz[1:0], ad[1:0], hp[0]);
            bad   = exp_bad(sz[1:0], ad[1:0]);
            spl   = hp[0] && (sz == 0) && !bad;
            lanes = (wr[0] || md[0]) ? ~m : 4'hF;   // R6 qualification

            // Present the request while idle.
            req_size = sz[1:0]; req_addr = ad[1:0]; req_write = wr[0];
            port_half = hp[0]; strobe_mode = md[0]; req_valid = 1'b1;
            check(req_ready, "R8 ready before request", req_ready, 1);

            @(negedge clk);
            // Stray request while busy (R8): must be ignored.
            req_size = 2'b01; req_addr = 2'b11; req_write = 1'b1;
            port_half = 1'b0; strobe_mode = 1'b1;
            check(!req_ready, "R8 busy after accept", req_ready, 0);
            if (bad) begin
                check(err, "R7 err pulse", err, 1);
                check(lane_en_n == 4'hF, "R7 no lanes on err", lane_en_n, 4'hF);
                check(!done, "R7 no done on err", done, 0);
            end else begin
                check(lane_en_n == lanes, spl ? "R5 first beat lanes" :
                      (hp ? "R4 narrow lanes" : (sz == 1 ? "R2 byte lanes" : "R3 wide lanes")),
                      lane_en_n, lanes);
                check(done == !spl, spl ? "R5 no done on first beat" : "R6 done single beat",
                      done, !spl);
                check(ext_addr_hw == (spl ? 1'b0 : ad[1]), spl ? "R5 first beat addr" : "R9 addr bit",
                      ext_addr_hw, spl ? 0 : ad[1]);
                check(!err, "R7 no err on aligned", err, 0);
            end

            @(negedge clk);
            req_valid = 1'b0;
            if (spl) begin
                check(lane_en_n == lanes, "R5 second beat lanes", lane_en_n, lanes);
                check(done, "R5 done on second beat", done, 1);
                check(ext_addr_hw == 1'b1, "R5 second beat addr", ext_addr_hw, 1);
                check(!req_ready, "R8 busy in second beat", req_ready, 0);
                @(negedge clk);
            end
            // Back in idle with no trace of the stray request (R8, R1).
            check_idle("post-transfer");
        end

        finish_run();
    end

endmodule